// File: doc/BRIEF.md
# MMIO Window to Partition Decoder

This block decodes a 64-bit memory-mapped I/O address into a partition number, the identifier that isolates one function's traffic from all others. It holds a table of address windows. Each window is described by a base and a mask, and the mask forces a power-of-two size aligned to that size. Each window also carries a mode that sets how an address inside it becomes a partition number: the window can be split into equal segments that map straight onto partitions, it can send the whole window to one partition, each segment can be remapped through a small per-window lookup table, or the window can be split into 8, 64 or 128 segments counted from a programmable base partition.

Software programs the table through a single write port. A write selects an entry, selects one of four fields (base, mask, control, remap slot) and supplies the data. A write that would create an illegal entry is dropped, and a reject pulse reports it. Lookups come in on a separate port. The result is registered and carries a hit flag, the partition number and the index of the winning entry.

Top module: `pe_win_decoder`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_hit` are 0 and every entry is disabled, so any lookup misses.
- R2: A lookup presented with `lk_valid` high at a clock edge produces its result with `rsp_valid` high after that same edge. When no lookup was presented, `rsp_valid` and `rsp_hit` are 0.
- R3: An entry matches when `(lk_addr ^ base) & mask` is zero. A mask write (`wr_sel`=1) is accepted only when the inverted mask is a contiguous run of low ones, which gives a power-of-two aligned window. Any other mask is rejected and the stored mask is kept.
- R4: In control mode code 1 (segmented), the window splits into 256 equal segments. The segment index is taken from the top 8 address bits inside the window, and segment n gives partition n.
- R5: In mode code 2 (single), every address in the window gives the partition stored in control bits [15:8].
- R6: In mode code 3 (remap), the window splits into 8 segments. Segment n gives the partition stored in remap slot n of that entry, which is written with `wr_sel`=3, `wr_seg`=n and data bits [7:0]. Slots reset to 0.
- R7: In mode code 4 (extended), control bits [17:16] select 8 (0), 64 (1) or 128 (2) segments. Segment n gives partition (base + n), where the base partition is in control bits [15:8].
- R8: A control write (`wr_sel`=2) is rejected, and the entry is left unchanged, in three cases: mode code above 4; extended mode with count select 3; extended mode whose base partition is not a multiple of the segment count. `wr_reject` is high for one cycle after any rejected write and never follows a base or remap write.
- R9: When several enabled entries match, the lowest-numbered entry gives the result.
- R10: On a miss, `rsp_hit` is 0 and `rsp_pe` and `rsp_idx` are 0. A disabled entry (mode code 0) never matches.
- R11: A write changes the table at the clock edge it is sampled on. A lookup in the same cycle sees the old table, and a lookup in the next cycle sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Field select: 0 base, 1 mask, 2 control, 3 remap slot |
| wr_idx | input | 4 | Entry index of the write |
| wr_seg | input | 3 | Remap slot index of the write |
| wr_data | input | 64 | Write data |
| wr_reject | output | 1 | Pulses one cycle after a rejected write |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 64 | Lookup address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | An enabled entry matched |
| rsp_pe | output | 8 | Partition number |
| rsp_idx | output | 4 | Winning entry index |

## Verification
Every lookup result and every reject pulse is due one clock edge after the cycle that drives it. The bench drives inputs on the falling edge and reads outputs on the next falling edge, one rising edge later. The lookup driver pushes the expected hit, partition and index into a queue when it drives the request. A monitor pops one item for each cycle in which `rsp_valid` is high, so an early, late or missing result shows up as a mismatch or as a leftover item. The same-cycle write-and-lookup case is driven in one task, so the old-table result is due on the first edge and the new-table result on the next.

// File: rtl/pe_win_pkg.sv
package pe_win_pkg;

    typedef enum logic [2:0] {
        WM_OFF   = 3'd0,
        WM_SEG   = 3'd1,
        WM_SOLO  = 3'd2,
        WM_REMAP = 3'd3,
        WM_EXT   = 3'd4
    } win_mode_e;

    typedef enum logic [1:0] {
        WS_BASE  = 2'd0,
        WS_MASK  = 2'd1,
        WS_CTRL  = 2'd2,
        WS_REMAP = 2'd3
    } wr_sel_e;

    // log2 of the extended-mode segment count, 0 for the illegal select
    function automatic logic [2:0] ext_bits(input logic [1:0] cnt_sel);
        case (cnt_sel)
            2'd0:    return 3'd3;
            2'd1:    return 3'd6;
            2'd2:    return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/pe_win_table.sv
module pe_win_table
    import pe_win_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int N_WIN    = 16,
    parameter int PE_W     = 8,
    parameter int RMP_SEGS = 8,
    localparam int IDX_W   = $clog2(N_WIN),
    localparam int RS_W    = $clog2(RMP_SEGS),
    localparam int LG_W    = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [RS_W-1:0]   wr_seg,
    input  logic [ADDR_W-1:0] wr_data,
    output logic              wr_reject,
    output logic [ADDR_W-1:0] base_q [N_WIN],
    output logic [ADDR_W-1:0] mask_q [N_WIN],
    output logic [LG_W-1:0]   lg_q   [N_WIN],
    output logic [2:0]        mode_q [N_WIN],
    output logic [PE_W-1:0]   pe_q   [N_WIN],
    output logic [1:0]        ecnt_q [N_WIN],
    output logic [PE_W-1:0]   rmp_q  [N_WIN][RMP_SEGS]
);

    localparam int PE_LSB  = 8;
    localparam int CNT_LSB = PE_LSB + PE_W;

    function automatic logic [LG_W-1:0] low_zeros(input logic [ADDR_W-1:0] m);
        logic [LG_W-1:0] n;
        logic            stop;
        n    = '0;
        stop = 1'b0;
        for (int b = 0; b < ADDR_W; b++) begin
            if (!stop) begin
                if (m[b]) stop = 1'b1;
                else      n = n + 1'b1;
            end
        end
        return n;
    endfunction

    logic [ADDR_W-1:0] inv_mask;
    logic              mask_ok;
    logic [2:0]        c_mode;
    logic [PE_W-1:0]   c_pe;
    logic [1:0]        c_cnt;
    logic [PE_W-1:0]   c_align;
    logic              ctrl_bad;

    always_comb begin
        inv_mask = ~wr_data;
        mask_ok  = ((inv_mask & (inv_mask + ADDR_W'(1))) == '0);
        c_mode   = wr_data[2:0];
        c_pe     = wr_data[PE_LSB +: PE_W];
        c_cnt    = wr_data[CNT_LSB +: 2];
        c_align  = (PE_W'(1) << ext_bits(c_cnt)) - PE_W'(1);
        ctrl_bad = 1'b0;
        if (c_mode > WM_EXT) begin
            ctrl_bad = 1'b1;
        end else if (c_mode == WM_EXT) begin
            if (c_cnt == 2'd3)                ctrl_bad = 1'b1;
            else if ((c_pe & c_align) != '0)  ctrl_bad = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_reject <= 1'b0;
            for (int e = 0; e < N_WIN; e++) begin
                base_q[e] <= '0;
                mask_q[e] <= '0;
                lg_q[e]   <= LG_W'(ADDR_W);
                mode_q[e] <= WM_OFF;
                pe_q[e]   <= '0;
                ecnt_q[e] <= '0;
                for (int s = 0; s < RMP_SEGS; s++) rmp_q[e][s] <= '0;
            end
        end else begin
            wr_reject <= 1'b0;
            if (wr_en) begin
                unique case (wr_sel_e'(wr_sel))
                    WS_BASE: base_q[wr_idx] <= wr_data;
                    WS_MASK: begin
                        if (mask_ok) begin
                            mask_q[wr_idx] <= wr_data;
                            lg_q[wr_idx]   <= low_zeros(wr_data);
                        end else begin
                            wr_reject <= 1'b1;
                        end
                    end
                    WS_CTRL: begin
                        if (!ctrl_bad) begin
                            mode_q[wr_idx] <= c_mode;
                            pe_q[wr_idx]   <= c_pe;
                            ecnt_q[wr_idx] <= c_cnt;
                        end else begin
                            wr_reject <= 1'b1;
                        end
                    end
                    WS_REMAP: rmp_q[wr_idx][wr_seg] <= wr_data[PE_W-1:0];
                endcase
            end
        end
    end

endmodule

// File: rtl/pe_win_match.sv
module pe_win_match
    import pe_win_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int N_WIN    = 16,
    parameter int PE_W     = 8,
    parameter int RMP_SEGS = 8,
    localparam int RS_W    = $clog2(RMP_SEGS),
    localparam int LG_W    = $clog2(ADDR_W + 1)
) (
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [ADDR_W-1:0] base_i [N_WIN],
    input  logic [ADDR_W-1:0] mask_i [N_WIN],
    input  logic [LG_W-1:0]   lg_i   [N_WIN],
    input  logic [2:0]        mode_i [N_WIN],
    input  logic [PE_W-1:0]   pe_i   [N_WIN],
    input  logic [1:0]        ecnt_i [N_WIN],
    input  logic [PE_W-1:0]   rmp_i  [N_WIN][RMP_SEGS],
    output logic [N_WIN-1:0]  hit_o,
    output logic [PE_W-1:0]   pe_o   [N_WIN]
);

    for (genvar e = 0; e < N_WIN; e++) begin : g_ent
        logic [LG_W-1:0]   seg_bits;
        logic [LG_W-1:0]   shamt;
        logic [ADDR_W-1:0] seg;

        always_comb begin
            case (mode_i[e])
                WM_SEG:   seg_bits = LG_W'(PE_W);
                WM_REMAP: seg_bits = LG_W'(RS_W);
                WM_EXT:   seg_bits = LG_W'(ext_bits(ecnt_i[e]));
                default:  seg_bits = '0;
            endcase
            shamt = (lg_i[e] >= seg_bits) ? (lg_i[e] - seg_bits) : '0;
            seg   = (lk_addr >> shamt) & ((ADDR_W'(1) << seg_bits) - ADDR_W'(1));

            hit_o[e] = (mode_i[e] != WM_OFF) && (mode_i[e] <= WM_EXT) &&
                       (((lk_addr ^ base_i[e]) & mask_i[e]) == '0);

            case (mode_i[e])
                WM_SEG:   pe_o[e] = seg[PE_W-1:0];
                WM_SOLO:  pe_o[e] = pe_i[e];
                WM_REMAP: pe_o[e] = rmp_i[e][seg[RS_W-1:0]];
                WM_EXT:   pe_o[e] = pe_i[e] + seg[PE_W-1:0];
                default:  pe_o[e] = '0;
            endcase
        end
    end

endmodule

// File: rtl/pe_win_prio.sv
module pe_win_prio #(
    parameter int N_WIN  = 16,
    parameter int PE_W   = 8,
    localparam int IDX_W = $clog2(N_WIN)
) (
    input  logic [N_WIN-1:0] hit_i,
    input  logic [PE_W-1:0]  pe_i [N_WIN],
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [PE_W-1:0]  pe_o
);

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        pe_o  = '0;
        for (int e = N_WIN - 1; e >= 0; e--) begin
            if (hit_i[e]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(e);
                pe_o  = pe_i[e];
            end
        end
    end

endmodule

// File: rtl/pe_win_decoder.sv
module pe_win_decoder #(
    parameter int ADDR_W   = 64,
    parameter int N_WIN    = 16,
    parameter int PE_W     = 8,
    parameter int RMP_SEGS = 8,
    localparam int IDX_W   = $clog2(N_WIN),
    localparam int RS_W    = $clog2(RMP_SEGS),
    localparam int LG_W    = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [RS_W-1:0]   wr_seg,
    input  logic [ADDR_W-1:0] wr_data,
    output logic              wr_reject,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PE_W-1:0]   rsp_pe,
    output logic [IDX_W-1:0]  rsp_idx
);

    logic [ADDR_W-1:0] base_q [N_WIN];
    logic [ADDR_W-1:0] mask_q [N_WIN];
    logic [LG_W-1:0]   lg_q   [N_WIN];
    logic [2:0]        mode_q [N_WIN];
    logic [PE_W-1:0]   pe_q   [N_WIN];
    logic [1:0]        ecnt_q [N_WIN];
    logic [PE_W-1:0]   rmp_q  [N_WIN][RMP_SEGS];
    logic [N_WIN-1:0]  hit_vec;
    logic [PE_W-1:0]   pe_vec [N_WIN];
    logic              sel_any;
    logic [IDX_W-1:0]  sel_idx;
    logic [PE_W-1:0]   sel_pe;

    pe_win_table #(.ADDR_W(ADDR_W), .N_WIN(N_WIN), .PE_W(PE_W), .RMP_SEGS(RMP_SEGS)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_seg(wr_seg), .wr_data(wr_data), .wr_reject(wr_reject),
        .base_q(base_q), .mask_q(mask_q), .lg_q(lg_q), .mode_q(mode_q),
        .pe_q(pe_q), .ecnt_q(ecnt_q), .rmp_q(rmp_q)
    );

    pe_win_match #(.ADDR_W(ADDR_W), .N_WIN(N_WIN), .PE_W(PE_W), .RMP_SEGS(RMP_SEGS)) u_match (
        .lk_addr(lk_addr), .base_i(base_q), .mask_i(mask_q), .lg_i(lg_q),
        .mode_i(mode_q), .pe_i(pe_q), .ecnt_i(ecnt_q), .rmp_i(rmp_q),
        .hit_o(hit_vec), .pe_o(pe_vec)
    );

    pe_win_prio #(.N_WIN(N_WIN), .PE_W(PE_W)) u_prio (
        .hit_i(hit_vec), .pe_i(pe_vec), .any_o(sel_any), .idx_o(sel_idx), .pe_o(sel_pe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pe    <= '0;
            rsp_idx   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && sel_any;
            rsp_pe    <= (lk_valid && sel_any) ? sel_pe  : '0;
            rsp_idx   <= (lk_valid && sel_any) ? sel_idx : '0;
        end
    end

endmodule

// File: rtl/pe_win_decoder_chk.sv
module pe_win_decoder_chk #(
    parameter int PE_W  = 8,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             wr_reject,
    input logic             lk_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [PE_W-1:0]  rsp_pe,
    input logic [IDX_W-1:0] rsp_idx
);

    assert_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    assert_nolk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit));

    assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_pe == '0 && rsp_idx == '0));

    assert_rej_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_sel == 2'd0 || wr_sel == 2'd3) |=> !wr_reject);

endmodule

bind pe_win_decoder pe_win_decoder_chk #(.PE_W(PE_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/pe_win_decoder_bench.sv
module pe_win_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [3:0]  wr_idx = '0;
    logic [2:0]  wr_seg = '0;
    logic [63:0] wr_data = '0;
    logic        wr_reject;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [7:0]  rsp_pe;
    logic [3:0]  rsp_idx;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct packed {
        logic       hit;
        logic [7:0] pe;
        logic [3:0] idx;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];

    always #5 clk = ~clk;

    pe_win_decoder u_pe_win_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_seg(wr_seg), .wr_data(wr_data), .wr_reject(wr_reject),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_pe(rsp_pe), .rsp_idx(rsp_idx)
    );

    // monitor: one expected item per valid response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2: unexpected response hit=%0d pe=%0h idx=%0d, expected none",
                         rsp_hit, rsp_pe, rsp_idx);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_hit !== e.hit || rsp_pe !== e.pe || rsp_idx !== e.idx) begin
                    bad++;
                    $display("FAIL %s: got hit=%0d pe=%0h idx=%0d, expected hit=%0d pe=%0h idx=%0d",
                             t, rsp_hit, rsp_pe, rsp_idx, e.hit, e.pe, e.idx);
                end
            end
        end
    end

    task automatic check(input bit ok, input string t, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0h, expected %0h", t, act, exp);
        end
    endtask

    task automatic lookup(input logic [63:0] a, input logic h, input logic [7:0] p,
                          input logic [3:0] i, input string t);
        lk_valid = 1'b1;
        lk_addr  = a;
        exp_q.push_back('{hit: h, pe: p, idx: i});
        tag_q.push_back(t);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [3:0] i, input logic [2:0] g,
                      input logic [63:0] d, input logic rej, input string t);
        wr_en   = 1'b1;
        wr_sel  = s;
        wr_idx  = i;
        wr_seg  = g;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(wr_reject === rej, t, longint'(wr_reject), longint'(rej));
    endtask

    task automatic wr_and_lookup(input logic [1:0] s, input logic [3:0] i, input logic [63:0] d,
                                 input logic [63:0] a, input logic h, input logic [7:0] p,
                                 input logic [3:0] li, input string t);
        wr_en    = 1'b1;
        wr_sel   = s;
        wr_idx   = i;
        wr_seg   = '0;
        wr_data  = d;
        lk_valid = 1'b1;
        lk_addr  = a;
        exp_q.push_back('{hit: h, pe: p, idx: li});
        tag_q.push_back(t);
        @(negedge clk);
        wr_en    = 1'b0;
        lk_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_hit === 1'b0, "R1 reset outputs",
              longint'({rsp_valid, rsp_hit}), 0);
        lookup(64'h1_0050_0000, 1'b0, 8'h00, 4'd0, "R1 empty table misses");

        // entry 0: segmented, 256 MB window at 4 GB
        wr(2'd0, 4'd0, 3'd0, 64'h1_0000_0000, 1'b0, "R3 base write");
        wr(2'd1, 4'd0, 3'd0, 64'hFFFF_FFFF_F000_0000, 1'b0, "R3 good mask accepted");
        wr(2'd2, 4'd0, 3'd0, 64'h1, 1'b0, "R4 ctrl accepted");
        lookup(64'h1_0050_0000, 1'b1, 8'h05, 4'd0, "R4 segment 5");
        lookup(64'h1_0FF0_0000, 1'b1, 8'hFF, 4'd0, "R4 last segment");
        lookup(64'h1_0000_0000, 1'b1, 8'h00, 4'd0, "R4 first segment");

        // entry 1: single partition 0x42, 16 MB
        wr(2'd0, 4'd1, 3'd0, 64'h2_0000_0000, 1'b0, "R3 base write");
        wr(2'd1, 4'd1, 3'd0, 64'hFFFF_FFFF_FF00_0000, 1'b0, "R3 mask write");
        wr(2'd2, 4'd1, 3'd0, 64'h4202, 1'b0, "R5 ctrl accepted");
        lookup(64'h2_00AB_CDEF, 1'b1, 8'h42, 4'd1, "R5 single partition");

        // entry 2: remap, 8 MB
        wr(2'd0, 4'd2, 3'd0, 64'h3_0000_0000, 1'b0, "R3 base write");
        wr(2'd1, 4'd2, 3'd0, 64'hFFFF_FFFF_FF80_0000, 1'b0, "R3 mask write");
        wr(2'd2, 4'd2, 3'd0, 64'h3, 1'b0, "R6 ctrl accepted");
        wr(2'd3, 4'd2, 3'd3, 64'h99, 1'b0, "R6 remap slot write");
        wr(2'd3, 4'd2, 3'd0, 64'h11, 1'b0, "R6 remap slot write");
        lookup(64'h3_0030_0000, 1'b1, 8'h99, 4'd2, "R6 slot 3");
        lookup(64'h3_0000_0000, 1'b1, 8'h11, 4'd2, "R6 slot 0");
        lookup(64'h3_0070_0000, 1'b1, 8'h00, 4'd2, "R6 unwritten slot");

        // entry 3: extended, 64 MB, disabled first
        wr(2'd0, 4'd3, 3'd0, 64'h4_0000_0000, 1'b0, "R3 base write");
        wr(2'd1, 4'd3, 3'd0, 64'hFFFF_FFFF_FC00_0000, 1'b0, "R3 mask write");
        lookup(64'h4_0070_0000, 1'b0, 8'h00, 4'd0, "R10 disabled entry misses");
        wr(2'd2, 4'd3, 3'd0, 64'h1_4004, 1'b0, "R7 ctrl 64 segments accepted");
        lookup(64'h4_0070_0000, 1'b1, 8'h47, 4'd3, "R7 64 segments base 0x40");
        wr(2'd2, 4'd3, 3'd0, 64'h1_4104, 1'b1, "R8 unaligned base rejected");
        lookup(64'h4_0070_0000, 1'b1, 8'h47, 4'd3, "R8 entry unchanged");
        wr(2'd2, 4'd3, 3'd0, 64'h3_4004, 1'b1, "R8 count select 3 rejected");
        wr(2'd2, 4'd3, 3'd0, 64'h5, 1'b1, "R8 mode code 5 rejected");
        lookup(64'h4_0070_0000, 1'b1, 8'h47, 4'd3, "R8 entry unchanged");
        wr(2'd2, 4'd3, 3'd0, 64'h2_8004, 1'b0, "R7 ctrl 128 segments accepted");
        lookup(64'h4_0070_0000, 1'b1, 8'h8E, 4'd3, "R7 128 segments");
        wr(2'd2, 4'd3, 3'd0, 64'h2_4004, 1'b1, "R8 base 0x40 with 128 rejected");
        lookup(64'h4_0070_0000, 1'b1, 8'h8E, 4'd3, "R8 entry unchanged");
        wr(2'd2, 4'd3, 3'd0, 64'h0804, 1'b0, "R7 ctrl 8 segments accepted");
        lookup(64'h4_0380_0000, 1'b1, 8'h0F, 4'd3, "R7 8 segments last");
        lookup(64'h4_0070_0000, 1'b1, 8'h08, 4'd3, "R7 8 segments first");

        // non-contiguous mask rejected, stored mask kept
        wr(2'd1, 4'd1, 3'd0, 64'hFFFF_0000_FFFF_0000, 1'b1, "R3 bad mask rejected");
        lookup(64'h2_00AB_CDEF, 1'b1, 8'h42, 4'd1, "R3 mask unchanged");
        lookup(64'h2_0100_0000, 1'b0, 8'h00, 4'd0, "R3 outside window misses");

        // entry 5 overlaps entry 1
        wr(2'd0, 4'd5, 3'd0, 64'h2_0000_0000, 1'b0, "R9 base write");
        wr(2'd1, 4'd5, 3'd0, 64'hFFFF_FFFF_F000_0000, 1'b0, "R9 mask write");
        wr(2'd2, 4'd5, 3'd0, 64'h7702, 1'b0, "R9 ctrl write");
        lookup(64'h2_00AB_CDEF, 1'b1, 8'h42, 4'd1, "R9 lower entry wins");
        lookup(64'h2_0200_0000, 1'b1, 8'h77, 4'd5, "R9 only upper matches");

        // write and lookup in the same cycle, then the next cycle
        wr_and_lookup(2'd2, 4'd1, 64'h0, 64'h2_00AB_CDEF, 1'b1, 8'h42, 4'd1, "R11 same cycle sees old");
        lookup(64'h2_00AB_CDEF, 1'b1, 8'h77, 4'd5, "R11 next cycle sees new");

        lookup(64'h9_0000_0000, 1'b0, 8'h00, 4'd0, "R10 unmapped address");
        @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule